// File: doc/BRIEF.md
# Dual-Class Vectored Interrupt Controller

This block collects 64 level-sensitive interrupt inputs and presents them to a processor as two request lines. One is a normal request, arbitrated by a 4-bit priority per source and gated by a software threshold. The other is a fast request that bypasses priority. Software sets up and observes the block through a 32-bit register port that has a write strobe, a 7-bit byte address, write data and combinational read data.

Each source has four settings: an enable bit, a class bit that picks the normal or the fast path, a 4-bit priority and a force bit that raises the source from software. A single source can be switched on or off by writing its number to a dedicated register, so no read-modify-write of the enable vectors is needed. Two vector registers report the winning source of each class. Pending registers show every source that is currently asserting each line.

All settings are flops that update on the clock edge that captures a write. The request lines, the pending views and the vector registers are combinational functions of those flops and of the raw inputs.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the block is in its idle state. Every source is disabled, of normal class, priority 0 and not forced. The mask register (0x04) reads 0x1F, the control register (0x00) reads 0, the normal vector (0x40) reads 0xFFFF0000, the fast vector (0x44) reads 0xFFFFFFFF, and both request lines are low.
- R2: Writing a value n < 64 to 0x08 sets the enable bit of source n and leaves every other enable bit unchanged. Enable bits read at 0x10 (sources 63..32, source 32+i at bit i) and at 0x14 (sources 31..0, source i at bit i), and both registers can also be written directly.
- R3: Writing a value n < 64 to 0x0C clears the enable bit of source n and leaves every other enable bit unchanged.
- R4: A write of 64 or more to 0x08 or 0x0C changes no enable bit. Both registers read as 0.
- R5: The class bits are at 0x18 (high half) and 0x1C (low half), with the same bit layout as the enable bits. A 1 sends the source to the fast path and a 0 sends it to the normal path.
- R6: The priority of source n occupies bits [4*(n%8)+3 : 4*(n%8)] of the priority register at address 0x20 + 4*(7 - n/8). The register reads back what was written.
- R7: A source is effective when its raw input or its force bit is 1. The force bits are read and written at 0x50 (high) and 0x54 (low). The raw inputs read at 0x48 (high) and 0x4C (low).
- R8: The normal-pending bits read at 0x58/0x5C and the fast-pending bits at 0x60/0x64. Such a bit is 1 when its source is effective, enabled and of that class.
- R9: The normal winner is the normal-pending source with the highest priority. Among equal priorities the highest source number wins. 0x40 reads the winner's number in [31:16] and its priority in [15:0].
- R10: norm_irq is high exactly when a normal winner exists and its priority is strictly greater than the 5-bit mask value. A mask of 16 or more blocks every source.
- R11: 0x44 reads the highest-numbered fast-pending source, or 0xFFFFFFFF when there is none. fast_irq is high exactly when at least one source is fast-pending.
- R12: The control register at 0x00 stores all 32 written bits. The mask register at 0x04 stores bits [4:0] of the write, and its upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_src | input | 64 | Raw level-sensitive interrupt inputs |
| norm_irq | output | 1 | Normal interrupt request |
| fast_irq | output | 1 | Fast interrupt request |

## Verification
A register write takes effect at the rising edge that captures it. A read of any register, both request lines and both vectors therefore show the new state one edge after the write and need no further latency. A change on irq_src reaches the pending views, the vectors and the requests in the same cycle, with no register in the path. The bench drives writes at the falling edge and releases the strobe at the next falling edge. It changes the read address or irq_src there and samples 2 ns later, so every comparison falls in the settled half of a cycle, well away from the capturing edge.

// File: rtl/vic_pkg.sv
// Package: register offsets and size constants shared by the interrupt controller.
// Assumes 64 sources split into two 32-bit halves, which the register layout needs.
package vic_pkg;
    localparam int NUM_SRC = 64;
    localparam int PRIO_W  = 4;
    localparam int MASK_W  = 5;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int NGRP    = NUM_SRC * PRIO_W / DATA_W;

    localparam logic [ADDR_W-1:0] A_CTRL   = 7'h00;
    localparam logic [ADDR_W-1:0] A_MASK   = 7'h04;
    localparam logic [ADDR_W-1:0] A_ENNUM  = 7'h08;
    localparam logic [ADDR_W-1:0] A_DISNUM = 7'h0C;
    localparam logic [ADDR_W-1:0] A_ENH    = 7'h10;
    localparam logic [ADDR_W-1:0] A_ENL    = 7'h14;
    localparam logic [ADDR_W-1:0] A_CLSH   = 7'h18;
    localparam logic [ADDR_W-1:0] A_CLSL   = 7'h1C;
    localparam logic [ADDR_W-1:0] A_PRIO0  = 7'h20;
    localparam logic [ADDR_W-1:0] A_NVEC   = 7'h40;
    localparam logic [ADDR_W-1:0] A_FVEC   = 7'h44;
    localparam logic [ADDR_W-1:0] A_RAWH   = 7'h48;
    localparam logic [ADDR_W-1:0] A_RAWL   = 7'h4C;
    localparam logic [ADDR_W-1:0] A_FRCH   = 7'h50;
    localparam logic [ADDR_W-1:0] A_FRCL   = 7'h54;
    localparam logic [ADDR_W-1:0] A_NPNDH  = 7'h58;
    localparam logic [ADDR_W-1:0] A_NPNDL  = 7'h5C;
    localparam logic [ADDR_W-1:0] A_FPNDH  = 7'h60;
    localparam logic [ADDR_W-1:0] A_FPNDL  = 7'h64;
endpackage

// File: rtl/vic_regs.sv
// Module: vic_regs
// Holds every software-writable setting: control, mask, enable, class, force
// and the packed priority groups. It assumes one write per cycle, addressed by
// exact byte address, and it ignores writes to unknown or read-only addresses.
module vic_regs
    import vic_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          ctrl_q,
    output logic [MASK_W-1:0]          mask_q,
    output logic [NUM_SRC-1:0]         en_q,
    output logic [NUM_SRC-1:0]         cls_q,
    output logic [NUM_SRC-1:0]         frc_q,
    output logic [NUM_SRC*PRIO_W-1:0]  prio_q
);
    localparam int HALF = NUM_SRC / 2;

    logic num_ok;
    assign num_ok = (wdata < DATA_W'(NUM_SRC));

    // Purpose: control and mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '1;
        end else if (wr) begin
            if (addr == A_CTRL) ctrl_q <= wdata;
            if (addr == A_MASK) mask_q <= wdata[MASK_W-1:0];
        end
    end

    // Purpose: enable bits, by number or by whole half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr) begin
            case (addr)
                A_ENNUM:  if (num_ok) en_q[wdata[IDX_W-1:0]] <= 1'b1;
                A_DISNUM: if (num_ok) en_q[wdata[IDX_W-1:0]] <= 1'b0;
                A_ENH:    en_q[NUM_SRC-1:HALF] <= wdata;
                A_ENL:    en_q[HALF-1:0]       <= wdata;
                default:  ;
            endcase
        end
    end

    // Purpose: class and force bits, written by halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q <= '0;
            frc_q <= '0;
        end else if (wr) begin
            case (addr)
                A_CLSH:  cls_q[NUM_SRC-1:HALF] <= wdata;
                A_CLSL:  cls_q[HALF-1:0]       <= wdata;
                A_FRCH:  frc_q[NUM_SRC-1:HALF] <= wdata;
                A_FRCL:  frc_q[HALF-1:0]       <= wdata;
                default: ;
            endcase
        end
    end

    // One priority register per group of eight sources; the highest group sits lowest.
    for (genvar g = 0; g < NGRP; g++) begin : g_prio
        localparam logic [ADDR_W-1:0] GADDR = ADDR_W'(int'(A_PRIO0) + 4 * (NGRP - 1 - g));
        // Purpose: store the packed priorities of group g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[g*DATA_W +: DATA_W] <= '0;
            else if (wr && addr == GADDR)
                prio_q[g*DATA_W +: DATA_W] <= wdata;
        end
    end

    // R2
    en_num_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_ENNUM && wdata < DATA_W'(NUM_SRC))
        |=> en_q[$past(wdata[IDX_W-1:0])]);

    // R3
    dis_num_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_DISNUM && wdata < DATA_W'(NUM_SRC))
        |=> !en_q[$past(wdata[IDX_W-1:0])]);

    // R4
    num_range_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == A_ENNUM || addr == A_DISNUM) && wdata >= DATA_W'(NUM_SRC))
        |=> $stable(en_q));
endmodule

// File: rtl/vic_norm_arb.sv
// Module: vic_norm_arb
// Picks the normal-pending source with the highest priority. Ties go to the
// higher source number. Purely combinational, one linear scan.
module vic_norm_arb
    import vic_pkg::*;
(
    input  logic [NUM_SRC-1:0]         pend,
    input  logic [NUM_SRC*PRIO_W-1:0]  prio,
    output logic                       found,
    output logic [IDX_W-1:0]           win_idx,
    output logic [PRIO_W-1:0]          win_prio
);
    // Purpose: scan upward; '>=' lets a later equal priority take over.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (!found || prio[i*PRIO_W +: PRIO_W] >= win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/vic_fast_sel.sv
// Module: vic_fast_sel
// Reports the highest-numbered set bit of the fast-pending vector.
module vic_fast_sel
    import vic_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // Purpose: the last set bit in the upward scan wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
// Module: vec_irq_ctrl (top)
// Dual-class vectored interrupt controller for 64 level inputs. It forms the
// pending sets, arbitrates them, applies the normal mask and decodes reads.
// It assumes level sources that stay asserted until serviced.
module vec_irq_ctrl
    import vic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [6:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [63:0]        irq_src,
    output logic               norm_irq,
    output logic               fast_irq
);
    localparam int HALF = NUM_SRC / 2;

    logic [DATA_W-1:0]         ctrl_q;
    logic [MASK_W-1:0]         mask_q;
    logic [NUM_SRC-1:0]        en_q, cls_q, frc_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_q;
    logic [NUM_SRC-1:0]        eff, npend, fpend;
    logic                      n_found, f_found;
    logic [IDX_W-1:0]          n_idx, f_idx;
    logic [PRIO_W-1:0]         n_prio;
    logic [DATA_W-1:0]         nvec, fvec;
    logic [DATA_W-1:0]         prio_rd;

    vic_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .ctrl_q(ctrl_q), .mask_q(mask_q), .en_q(en_q), .cls_q(cls_q),
        .frc_q(frc_q), .prio_q(prio_q)
    );

    // Effective and pending sets.
    assign eff   = irq_src | frc_q;
    assign npend = eff & en_q & ~cls_q;
    assign fpend = eff & en_q &  cls_q;

    vic_norm_arb u_narb (
        .pend(npend), .prio(prio_q),
        .found(n_found), .win_idx(n_idx), .win_prio(n_prio)
    );

    vic_fast_sel u_fsel (.pend(fpend), .found(f_found), .idx(f_idx));

    // Requests: the normal winner must beat the 5-bit threshold.
    assign norm_irq = n_found && ({1'b0, n_prio} > mask_q);
    assign fast_irq = f_found;

    assign nvec = n_found ? {16'(n_idx), 16'(n_prio)} : {16'hFFFF, 16'h0000};
    assign fvec = f_found ? DATA_W'(f_idx) : '1;

    // Purpose: select the priority group addressed (highest group at lowest address).
    always_comb begin
        prio_rd = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (bus_addr == ADDR_W'(int'(A_PRIO0) + 4 * (NGRP - 1 - g)))
                prio_rd = prio_q[g*DATA_W +: DATA_W];
        end
    end

    // Purpose: combinational read decode.
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_MASK:  bus_rdata = DATA_W'(mask_q);
            A_ENH:   bus_rdata = en_q[NUM_SRC-1:HALF];
            A_ENL:   bus_rdata = en_q[HALF-1:0];
            A_CLSH:  bus_rdata = cls_q[NUM_SRC-1:HALF];
            A_CLSL:  bus_rdata = cls_q[HALF-1:0];
            A_NVEC:  bus_rdata = nvec;
            A_FVEC:  bus_rdata = fvec;
            A_RAWH:  bus_rdata = irq_src[NUM_SRC-1:HALF];
            A_RAWL:  bus_rdata = irq_src[HALF-1:0];
            A_FRCH:  bus_rdata = frc_q[NUM_SRC-1:HALF];
            A_FRCL:  bus_rdata = frc_q[HALF-1:0];
            A_NPNDH: bus_rdata = npend[NUM_SRC-1:HALF];
            A_NPNDL: bus_rdata = npend[HALF-1:0];
            A_FPNDH: bus_rdata = fpend[NUM_SRC-1:HALF];
            A_FPNDL: bus_rdata = fpend[HALF-1:0];
            default: bus_rdata = prio_rd;
        endcase
    end

    // R10
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        norm_irq |-> (mask_q < 5'd16));

    // R9
    norm_win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        norm_irq |-> (npend[n_idx] && !cls_q[n_idx]));

    // R11
    fast_win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_irq |-> (fpend[f_idx] && en_q[f_idx]));
endmodule

// File: tb/vec_irq_ctrl_bench.sv
// Bench: one loop walks a vector table of write/read/expect entries, then directed
// tests cover reset, raw inputs, priority ties and the mask ceiling.
module vec_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_src = '0;
    logic        norm_irq, fast_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    vec_irq_ctrl u_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
        .norm_irq(norm_irq), .fast_irq(fast_irq)
    );

    // Entry: {write addr 7, write data 32, read addr 7, expected 32, nirq 1, firq 1, req 8}
    localparam int NV = 18;
    localparam logic [87:0] TBL [NV] = '{
        {7'h00, 32'hA5A5_0001, 7'h00, 32'hA5A5_0001, 1'b0, 1'b0, 8'd12}, // R12 control
        {7'h08, 32'd5,         7'h14, 32'h0000_0020, 1'b0, 1'b0, 8'd2},  // R2
        {7'h08, 32'd40,        7'h10, 32'h0000_0100, 1'b0, 1'b0, 8'd2},  // R2
        {7'h08, 32'd64,        7'h10, 32'h0000_0100, 1'b0, 1'b0, 8'd4},  // R4
        {7'h08, 32'd63,        7'h10, 32'h8000_0100, 1'b0, 1'b0, 8'd2},  // R2
        {7'h0C, 32'd40,        7'h10, 32'h8000_0000, 1'b0, 1'b0, 8'd3},  // R3
        {7'h0C, 32'd200,       7'h14, 32'h0000_0020, 1'b0, 1'b0, 8'd4},  // R4
        {7'h0C, 32'h7F,        7'h08, 32'h0000_0000, 1'b0, 1'b0, 8'd4},  // R4 reads 0
        {7'h3C, 32'h0070_0000, 7'h3C, 32'h0070_0000, 1'b0, 1'b0, 8'd6},  // R6 src5=7
        {7'h20, 32'hA000_0000, 7'h20, 32'hA000_0000, 1'b0, 1'b0, 8'd6},  // R6 src63=10
        {7'h54, 32'h0000_0020, 7'h5C, 32'h0000_0020, 1'b0, 1'b0, 8'd8},  // R7 R8, mask 1F
        {7'h04, 32'h0000_0006, 7'h40, 32'h0005_0007, 1'b1, 1'b0, 8'd9},  // R9 R10
        {7'h04, 32'h0000_0007, 7'h04, 32'h0000_0007, 1'b0, 1'b0, 8'd10}, // R10 equal blocks
        {7'h50, 32'h8000_0000, 7'h40, 32'h003F_000A, 1'b1, 1'b0, 8'd9},  // R9
        {7'h18, 32'h8000_0000, 7'h44, 32'h0000_003F, 1'b0, 1'b1, 8'd5},  // R5 R11
        {7'h40, 32'h0000_1234, 7'h60, 32'h8000_0000, 1'b0, 1'b1, 8'd8},  // R8 fast pend
        {7'h04, 32'hFFFF_FFE0, 7'h04, 32'h0000_0000, 1'b1, 1'b1, 8'd12}, // R12 mask width
        {7'h0C, 32'd63,        7'h44, 32'hFFFF_FFFF, 1'b1, 1'b0, 8'd11}  // R11 none
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
        bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 mask", 7'h04, 32'h1F);
        rd_chk("R1 ctrl", 7'h00, 32'h0);
        rd_chk("R1 enh", 7'h10, 32'h0);
        rd_chk("R1 enl", 7'h14, 32'h0);
        rd_chk("R1 clsl", 7'h1C, 32'h0);
        rd_chk("R1 prio", 7'h2C, 32'h0);
        rd_chk("R1 nvec", 7'h40, 32'hFFFF_0000);
        rd_chk("R1 fvec", 7'h44, 32'hFFFF_FFFF);
        chk("R1 norm_irq", 32'(norm_irq), 32'd0);
        chk("R1 fast_irq", 32'(fast_irq), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [87:0] e;
            string tag;
            e = TBL[i];
            tag = $sformatf("R%0d entry %0d", e[7:0], i);
            do_write(e[87:81], e[80:49]);
            rd_chk(tag, e[48:42], e[41:10]);
            chk({tag, " norm_irq"}, 32'(norm_irq), 32'(e[9]));
            chk({tag, " fast_irq"}, 32'(fast_irq), 32'(e[8]));
        end

        // Directed: raw inputs and ties (R7, R9)
        do_reset();
        do_write(7'h08, 32'd10);
        do_write(7'h08, 32'd20);
        do_write(7'h38, 32'h0000_0300);   // src10 prio 3
        do_write(7'h34, 32'h0003_0000);   // src20 prio 3
        do_write(7'h04, 32'h0);
        irq_src = (64'd1 << 10) | (64'd1 << 20);
        rd_chk("R7 raw low", 7'h4C, 32'h0010_0400);
        rd_chk("R7 raw high", 7'h48, 32'h0);
        rd_chk("R9 tie to higher number", 7'h40, 32'h0014_0003);
        chk("R10 irq on", 32'(norm_irq), 32'd1);
        do_write(7'h38, 32'h0000_0500);   // src10 prio 5
        rd_chk("R9 higher prio wins", 7'h40, 32'h000A_0005);
        // R10 mask ceiling
        do_write(7'h38, 32'h0000_0F00);   // src10 prio 15
        do_write(7'h04, 32'h10);
        #2 chk("R10 mask 0x10 blocks prio 15", 32'(norm_irq), 32'd0);
        do_write(7'h04, 32'h0E);
        #2 chk("R10 mask 0x0E passes prio 15", 32'(norm_irq), 32'd1);
        // R7 source removal is seen at once
        @(negedge clk);
        irq_src = '0;
        rd_chk("R7 no source", 7'h40, 32'hFFFF_0000);
        chk("R7 irq off", 32'(norm_irq), 32'd0);
        // R3 disable by number while source active
        irq_src = 64'd1 << 20;
        do_write(7'h0C, 32'd20);
        rd_chk("R3 disabled not pending", 7'h5C, 32'h0);
        rd_chk("R3 other enable kept", 7'h14, 32'h0000_0400);
        // R5 fast class from low half via raw input
        irq_src = 64'd1 << 10;
        do_write(7'h1C, 32'h0000_0400);
        rd_chk("R5 fast pend low", 7'h64, 32'h0000_0400);
        rd_chk("R11 fast vec", 7'h44, 32'h0000_000A);
        chk("R5 normal idle", 32'(norm_irq), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule